// File: doc/BRIEF.md
# Two-Master Shared-Credit Arbiter

This block lets two pipelined memory-mapped masters, an instruction fetch port and a load/store port, share one slave port. Each master has a share credit. The credit is the number of accepted word transfers it may complete before the grant is offered to the other master. With a credit equal to the cache-line length in words, a line fill or write-back reaches the slave as one unbroken run. An open row in a dynamic memory is then not thrashed by word-by-word interleaving of the two streams.

The grant is a small state machine with three states:
- `ST_IDLE`: nobody owns the slave.
- `ST_GNT_FE`: the fetch port owns the slave.
- `ST_GNT_LS`: the load/store port owns the slave.

Its transitions are:
- **pick**: from idle to a grant state. A lone requester wins. On a tie, the master not granted most recently wins.
- **keep**: stay in the grant state while the owner still requests and has credit left. A lone owner also stays when its credit runs out, and its credit is renewed.
- **hand over**: move to the other grant state. This happens when the owner's last credit is spent while the other master waits, or when the owner drops its request while the other master waits.
- **release**: return to idle when the owner drops its request and nobody waits.

A master that is not granted sees waitrequest held high. Each accepted read pushes the issuer's identity into an ordered queue. Every returning readdatavalid beat is steered to the master at the head of that queue. Both credit parameters must be at least 1; a zero credit stops elaboration.

Top module: `share_arbiter2`

## Requirements
- R1: While reset is held and right after it is released, both masters see waitrequest high and the slave sees read and write low.
- R2: A lone request from idle is granted at the next clock edge, so exactly one wait cycle is seen. After that, one transfer is accepted per cycle while the slave does not stall.
- R3: At most one master sees waitrequest low in any cycle. Address, read, write and write data reach the slave only from the granted master.
- R4: A granted master keeps the grant for CREDIT_FE (fetch) or CREDIT_LS (load/store) accepted transfers while the other master waits. At the edge that accepts the last of them, the grant passes to the waiting master.
- R5: A master with a credit of 1 completes a single word, then the waiting master is served.
- R6: A cycle in which the slave asserts waitrequest, or in which a read is held back by a full response queue, consumes no credit and does not move the grant.
- R7: When the owner drops its request before its credit is spent, the grant passes to a waiting master at the next edge. The waiting master's first transfer is then accepted two cycles after the owner's last one.
- R8: A lone requester keeps the grant past its credit with no lost cycle at the credit boundary.
- R9: When both masters request from idle, the master not granted most recently wins. After reset the fetch port wins.
- R10: Each readdatavalid beat is routed to the master that issued the matching read, in issue order. Read data goes to both masters unchanged. Every accepted read gets exactly one beat.
- R11: At most RSP_DEPTH reads are outstanding. When the queue is full, a read of the granted master is held with waitrequest and is not passed to the slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fe_addr | input | ADDR_W | Fetch master address |
| fe_rd | input | 1 | Fetch master read request |
| fe_wr | input | 1 | Fetch master write request |
| fe_wdata | input | DATA_W | Fetch master write data |
| fe_wait | output | 1 | Fetch master waitrequest |
| fe_rdata | output | DATA_W | Fetch master read data |
| fe_rvalid | output | 1 | Fetch master read data valid |
| ls_addr | input | ADDR_W | Load/store master address |
| ls_rd | input | 1 | Load/store master read request |
| ls_wr | input | 1 | Load/store master write request |
| ls_wdata | input | DATA_W | Load/store master write data |
| ls_wait | output | 1 | Load/store master waitrequest |
| ls_rdata | output | DATA_W | Load/store master read data |
| ls_rvalid | output | 1 | Load/store master read data valid |
| mem_addr | output | ADDR_W | Slave address |
| mem_rd | output | 1 | Slave read |
| mem_wr | output | 1 | Slave write |
| mem_wdata | output | DATA_W | Slave write data |
| mem_wait | input | 1 | Slave waitrequest |
| mem_rdata | input | DATA_W | Slave read data |
| mem_rvalid | input | 1 | Slave read data valid |

## Verification
The bench runs with a fetch credit of 8 and a load/store credit of 1. It checks the exact order of accepted words for simultaneous 16-word streams. A design that switched per word, or gave the grant back one word late, would produce a different interleave. Slave stalls are injected during a credited run; a design that charged stalled cycles against the credit would hand over early.

The bench measures the gap after an early release and the spacing of a 20-word lone stream, which catches a missed handoff or a bubble at the credit boundary. A slave latency longer than the response queue shows whether reads beyond the queue depth leak through, which would misroute or lose read data.

// File: rtl/shrarb_pkg.sv
package shrarb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_GNT_FE = 2'd1,
        ST_GNT_LS = 2'd2
    } arb_state_e;

    typedef enum logic {
        SRC_FE = 1'b0,
        SRC_LS = 1'b1
    } src_e;
endpackage

// File: rtl/shrarb_fsm.sv
module shrarb_fsm
    import shrarb_pkg::*;
#(
    parameter int CREDIT_FE = 1,
    parameter int CREDIT_LS = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_fe,
    input  logic       req_ls,
    input  logic       xfer,
    output arb_state_e state
);
    localparam int MAXC = (CREDIT_FE > CREDIT_LS) ? CREDIT_FE : CREDIT_LS;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    if (CREDIT_FE < 1 || CREDIT_LS < 1) begin : g_bad_credit
        $error("share credit must be at least 1");
    end

    arb_state_e     nxt;
    src_e           last_src;
    logic [CW-1:0]  used;
    logic [CW-1:0]  lim_m1;
    logic           last_word;

    assign lim_m1    = (state == ST_GNT_LS) ? CW'(CREDIT_LS - 1) : CW'(CREDIT_FE - 1);
    assign last_word = (used == lim_m1);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (req_fe && req_ls)
                    nxt = (last_src == SRC_FE) ? ST_GNT_LS : ST_GNT_FE;
                else if (req_fe)
                    nxt = ST_GNT_FE;
                else if (req_ls)
                    nxt = ST_GNT_LS;
                else
                    nxt = ST_IDLE;
            end
            ST_GNT_FE: begin
                if (!req_fe)
                    nxt = req_ls ? ST_GNT_LS : ST_IDLE;
                else if (xfer && last_word && req_ls)
                    nxt = ST_GNT_LS;
                else
                    nxt = ST_GNT_FE;
            end
            ST_GNT_LS: begin
                if (!req_ls)
                    nxt = req_fe ? ST_GNT_FE : ST_IDLE;
                else if (xfer && last_word && req_fe)
                    nxt = ST_GNT_FE;
                else
                    nxt = ST_GNT_LS;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            last_src <= SRC_LS;
            used     <= '0;
        end else begin
            state <= nxt;
            if (state == ST_GNT_FE)
                last_src <= SRC_FE;
            else if (state == ST_GNT_LS)
                last_src <= SRC_LS;
            if (nxt != state)
                used <= '0;
            else if (xfer)
                used <= last_word ? '0 : used + 1'b1;
        end
    end

    // R4
    credit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GNT_FE && req_fe && !(xfer && last_word)) |=> (state == ST_GNT_FE));

    // R6
    credit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GNT_LS && req_ls && !xfer) |=> (state == ST_GNT_LS && $stable(used)));

    // R7
    handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GNT_FE && !req_fe && req_ls) |=> (state == ST_GNT_LS));
endmodule

// File: rtl/shrarb_idq.sv
module shrarb_idq #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_id,
    input  logic pop,
    output logic head_id,
    output logic full
);
    localparam int PW = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    logic [DEPTH-1:0] mem;
    logic [PW-1:0]    wp, rp;
    logic [PW:0]      cnt;

    assign full    = (cnt == (PW+1)'(DEPTH));
    assign head_id = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem <= '0;
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) begin
                mem[wp] <= push_id;
                wp      <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (pop)
                rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    // R11
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R10
    no_orphan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
endmodule

// File: rtl/share_arbiter2.sv
module share_arbiter2
    import shrarb_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int CREDIT_FE = 1,
    parameter int CREDIT_LS = 1,
    parameter int RSP_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fe_addr,
    input  logic              fe_rd,
    input  logic              fe_wr,
    input  logic [DATA_W-1:0] fe_wdata,
    output logic              fe_wait,
    output logic [DATA_W-1:0] fe_rdata,
    output logic              fe_rvalid,
    input  logic [ADDR_W-1:0] ls_addr,
    input  logic              ls_rd,
    input  logic              ls_wr,
    input  logic [DATA_W-1:0] ls_wdata,
    output logic              ls_wait,
    output logic [DATA_W-1:0] ls_rdata,
    output logic              ls_rvalid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_wait,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);
    arb_state_e state;
    logic       q_full;
    logic       head_id;
    logic       xfer;
    logic       rd_acc;

    shrarb_fsm #(
        .CREDIT_FE (CREDIT_FE),
        .CREDIT_LS (CREDIT_LS)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_fe (fe_rd | fe_wr),
        .req_ls (ls_rd | ls_wr),
        .xfer   (xfer),
        .state  (state)
    );

    shrarb_idq #(
        .DEPTH (RSP_DEPTH)
    ) u_idq (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (rd_acc),
        .push_id (state == ST_GNT_LS),
        .pop     (mem_rvalid),
        .head_id (head_id),
        .full    (q_full)
    );

    always_comb begin
        mem_addr  = '0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = '0;
        fe_wait   = 1'b1;
        ls_wait   = 1'b1;
        unique case (state)
            ST_IDLE: ;
            ST_GNT_FE: begin
                mem_addr  = fe_addr;
                mem_rd    = fe_rd & ~q_full;
                mem_wr    = fe_wr;
                mem_wdata = fe_wdata;
                fe_wait   = mem_wait | (fe_rd & q_full);
            end
            ST_GNT_LS: begin
                mem_addr  = ls_addr;
                mem_rd    = ls_rd & ~q_full;
                mem_wr    = ls_wr;
                mem_wdata = ls_wdata;
                ls_wait   = mem_wait | (ls_rd & q_full);
            end
            default: ;
        endcase
    end

    assign xfer      = (mem_rd | mem_wr) & ~mem_wait;
    assign rd_acc    = mem_rd & ~mem_wait;
    assign fe_rdata  = mem_rdata;
    assign ls_rdata  = mem_rdata;
    assign fe_rvalid = mem_rvalid & (head_id == SRC_FE);
    assign ls_rvalid = mem_rvalid & (head_id == SRC_LS);

    // R3
    excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!fe_wait && !ls_wait));
endmodule

// File: tb/share_arbiter2_tb.sv
module share_arbiter2_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CI = 8;
    localparam int CL = 1;
    localparam int DEP = 4;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [AW-1:0] fe_addr = '0, ls_addr = '0, mem_addr;
    logic fe_rd = 0, fe_wr = 0, ls_rd = 0, ls_wr = 0;
    logic [DW-1:0] fe_wdata = '0, ls_wdata = '0, mem_wdata;
    logic fe_wait, ls_wait, fe_rvalid, ls_rvalid, mem_rd, mem_wr, mem_rvalid;
    logic [DW-1:0] fe_rdata, ls_rdata, mem_rdata;
    logic mem_wait = 1'b0;

    share_arbiter2 #(.ADDR_W(AW), .DATA_W(DW), .CREDIT_FE(CI), .CREDIT_LS(CL),
                     .RSP_DEPTH(DEP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .fe_addr(fe_addr), .fe_rd(fe_rd), .fe_wr(fe_wr), .fe_wdata(fe_wdata),
        .fe_wait(fe_wait), .fe_rdata(fe_rdata), .fe_rvalid(fe_rvalid),
        .ls_addr(ls_addr), .ls_rd(ls_rd), .ls_wr(ls_wr), .ls_wdata(ls_wdata),
        .ls_wait(ls_wait), .ls_rdata(ls_rdata), .ls_rvalid(ls_rvalid),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_wait(mem_wait), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid));

    int nchk = 0, nfail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // slave model: pipelined reads with fixed latency, optional stall pattern
    int   lat = 2;
    bit   stall_on = 0;
    logic pv [8];
    logic [31:0] pa [8];
    logic acc_s = 0;
    logic [31:0] acc_a = '0;
    initial for (int j = 0; j < 8; j++) begin pv[j] = 0; pa[j] = '0; end
    assign mem_rvalid = pv[0];
    assign mem_rdata  = pa[0] ^ KEY;

    always @(negedge clk) begin
        acc_s = mem_rd & ~mem_wait;
        acc_a = mem_addr;
    end
    always @(posedge clk) begin
        for (int j = 0; j < 7; j++) begin pv[j] <= pv[j+1]; pa[j] <= pa[j+1]; end
        pv[7] <= 1'b0;
        if (acc_s) begin pv[lat-1] <= 1'b1; pa[lat-1] <= acc_a; end
    end
    int sc = 0;
    always @(posedge clk) begin
        #1;
        sc++;
        mem_wait = stall_on && (sc % 3 == 1);
    end

    // monitor
    int log_who [64];
    int log_cyc [64];
    int log_n = 0, fe_stall = 0, ls_stall = 0, outs = 0, out_max = 0;
    logic [31:0] fq [256];
    logic [31:0] lq [256];
    int fh = 0, ft = 0, lh = 0, lt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit fa, la;
            fa = (fe_rd | fe_wr) & ~fe_wait;
            la = (ls_rd | ls_wr) & ~ls_wait;
            chk(!(fa && la), "R3 both masters accepted", int'({fa, la}), 1);
            if ((fe_rd | fe_wr) & fe_wait) fe_stall++;
            if ((ls_rd | ls_wr) & ls_wait) ls_stall++;
            if (fa) begin
                if (log_n < 64) begin log_who[log_n] = 0; log_cyc[log_n] = cyc; end
                log_n++;
                chk(mem_addr == fe_addr && mem_rd == fe_rd && mem_wr == fe_wr,
                    "R3 fetch forwarding", int'(mem_addr), int'(fe_addr));
                if (fe_rd) begin fq[ft[7:0]] = fe_addr; ft++; outs++; end
            end
            if (la) begin
                if (log_n < 64) begin log_who[log_n] = 1; log_cyc[log_n] = cyc; end
                log_n++;
                chk(mem_addr == ls_addr && mem_rd == ls_rd && mem_wr == ls_wr,
                    "R3 load/store forwarding", int'(mem_addr), int'(ls_addr));
                if (ls_wr) chk(mem_wdata == ls_wdata, "R3 write data", int'(mem_wdata), int'(ls_wdata));
                if (ls_rd) begin lq[lt[7:0]] = ls_addr; lt++; outs++; end
            end
            if (mem_rvalid) outs--;
            if (outs > out_max) out_max = outs;
            chk(!(fe_rvalid && ls_rvalid), "R10 beat to both", 1, 0);
            if (fe_rvalid) begin
                if (fh < ft) chk(fe_rdata == (fq[fh[7:0]] ^ KEY), "R10 fetch read data",
                                 int'(fe_rdata), int'(fq[fh[7:0]] ^ KEY));
                else chk(0, "R10 fetch orphan beat", 1, 0);
                fh++;
            end
            if (ls_rvalid) begin
                if (lh < lt) chk(ls_rdata == (lq[lh[7:0]] ^ KEY), "R10 load/store read data",
                                 int'(ls_rdata), int'(lq[lh[7:0]] ^ KEY));
                else chk(0, "R10 load/store orphan beat", 1, 0);
                lh++;
            end
        end
    end

    // master drivers
    task automatic drv_fe(input int n, input logic [31:0] base, input bit wr);
        for (int k = 0; k < n; k++) begin
            fe_addr = base + 32'(4 * k); fe_wdata = 32'hF000_0000 + 32'(k);
            fe_rd = !wr; fe_wr = wr;
            do @(negedge clk); while (fe_wait);
            @(posedge clk); #1;
        end
        fe_rd = 0; fe_wr = 0;
    endtask
    task automatic drv_ls(input int n, input logic [31:0] base, input bit wr);
        for (int k = 0; k < n; k++) begin
            ls_addr = base + 32'(4 * k); ls_wdata = 32'hD000_0000 + 32'(k);
            ls_rd = !wr; ls_wr = wr;
            do @(negedge clk); while (ls_wait);
            @(posedge clk); #1;
        end
        ls_rd = 0; ls_wr = 0;
    endtask

    // expected order from credits: owner takes min(credit, left) while other waits
    task automatic chk_order(input int first, input int nf, input int nl, input string tag);
        int rem [2];
        int cred [2];
        int own, idx;
        rem[0] = nf; rem[1] = nl; cred[0] = CI; cred[1] = CL;
        own = first; idx = 0;
        chk(log_n == nf + nl, {tag, " word count"}, log_n, nf + nl);
        while (rem[0] + rem[1] > 0) begin
            int take;
            if (rem[own] == 0) own ^= 1;
            take = (rem[own^1] > 0 && cred[own] < rem[own]) ? cred[own] : rem[own];
            for (int k = 0; k < take; k++) begin
                if (idx < log_n && idx < 64)
                    chk(log_who[idx] == own, {tag, " grant order"}, log_who[idx], own);
                idx++;
            end
            rem[own] -= take;
            own ^= 1;
        end
    endtask

    task automatic start_t();
        log_n = 0; fe_stall = 0; ls_stall = 0;
        @(posedge clk); #1;
    endtask
    task automatic drain_t(input string tag);
        repeat (16) @(posedge clk);
        #1;
        chk(fh == ft && lh == lt, {tag, " R10 every read answered"}, fh + lh, ft + lt);
    endtask

    task automatic t_reset();
        fe_rd = 1;
        @(negedge clk);
        chk(fe_wait && ls_wait && !mem_rd && !mem_wr, "R1 during reset",
            int'({fe_wait, ls_wait, mem_rd, mem_wr}), 4'b1100);
        fe_rd = 0;
        @(posedge clk); #1; rst_n = 1;
        @(negedge clk);
        chk(fe_wait && ls_wait && !mem_rd && !mem_wr, "R1 after release",
            int'({fe_wait, ls_wait, mem_rd, mem_wr}), 4'b1100);
    endtask

    task automatic t_rr_reset();
        start_t();
        fork drv_fe(2, 32'h100, 0); drv_ls(2, 32'h8000, 0); join
        drain_t("R9");
        chk_order(0, 2, 2, "R9 fetch first after reset");
    endtask

    task automatic t_lone();
        start_t();
        drv_fe(3, 32'h200, 0);
        drain_t("R2");
        chk_order(0, 3, 0, "R2");
        chk(fe_stall == 1, "R2 one arbitration cycle", fe_stall, 1);
        chk(log_cyc[2] - log_cyc[0] == 2, "R2 one word per cycle", log_cyc[2] - log_cyc[0], 2);
    endtask

    task automatic t_lines();
        start_t();
        fork drv_fe(16, 32'h1000, 0); drv_ls(16, 32'h9000, 0); join
        drain_t("R4");
        chk_order(1, 16, 16, "R4 R5 R9 credited interleave");
    endtask

    task automatic t_stall();
        lat = 3; stall_on = 1;
        start_t();
        fork drv_fe(10, 32'h2000, 0); drv_ls(3, 32'hA000, 1); join
        stall_on = 0;
        drain_t("R6");
        chk_order(0, 10, 3, "R6 stalls keep credit");
    endtask

    task automatic t_release();
        lat = 2;
        start_t();
        fork
            drv_fe(3, 32'h3000, 0);
            begin @(posedge clk); #1; drv_ls(2, 32'hB000, 0); end
        join
        drain_t("R7");
        chk_order(0, 3, 2, "R7 early release");
        chk(log_cyc[3] - log_cyc[2] == 2, "R7 handoff gap", log_cyc[3] - log_cyc[2], 2);
    endtask

    task automatic t_keep();
        start_t();
        drv_fe(20, 32'h4000, 0);
        drain_t("R8");
        chk_order(0, 20, 0, "R8");
        chk(fe_stall == 1, "R8 no bubble at credit boundary", fe_stall, 1);
        chk(log_cyc[19] - log_cyc[0] == 19, "R8 back-to-back", log_cyc[19] - log_cyc[0], 19);
    endtask

    task automatic t_full();
        lat = 8; out_max = 0;
        start_t();
        drv_fe(8, 32'h5000, 0);
        drain_t("R11");
        chk_order(0, 8, 0, "R11");
        chk(out_max == DEP, "R11 outstanding limited to depth", out_max, DEP);
        lat = 2;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        t_rr_reset();
        t_lone();
        t_lines();
        t_stall();
        t_release();
        t_keep();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule